// File: doc/BRIEF.md
# Warm Reset Sequencer with Cold Fallback

This block turns a warm reset request into a complete reset sequence. When warm reset is enabled it first asks the memory controller to bring memory into a safe state and waits for that controller's acknowledge. It then drives a warm reset pulse. If warm reset is disabled, the request goes straight to a cold reset. If the acknowledge does not arrive within a programmable number of slow reference ticks, the sequencer also gives up and issues a cold reset.

The timeout counts ticks of a slow 32 kHz reference. The tick arrives as a one-cycle enable that is already synchronized to the main clock. After the warm or cold pulse, the peripheral domain reset is held for a programmable multiple of 88 main-clock cycles. A status output then reports whether the last finished sequence was warm or cold.

The wait and stretch settings are captured when a request is accepted. A request that arrives while a sequence is running is dropped.

Top module: `wrst_seq`

## Requirements
- R1: After rst_ni is released, mem_req_o, warm_rst_o, cold_rst_o, dom_rst_o and last_cold_o are all low.
- R2: While warm_en_i is low, an idle request leads to cold_rst_o in the next cycle, and mem_req_o is never raised.
- R3: While warm_en_i is high, an idle request raises mem_req_o from the next cycle. mem_req_o stays high until mem_ack_i is seen, and the cycle after the acknowledge warm_rst_o is asserted.
- R4: The 2-bit bypass_sel_i selects the acknowledge timeout: 0 = wait forever, 1 = 16 ticks, 2 = 32 ticks, 3 = 64 ticks. When that many ticks have been counted without an acknowledge, cold_rst_o is asserted instead of warm_rst_o.
- R5: An acknowledge that arrives after fewer ticks than the limit still produces a warm reset.
- R6: The timeout advances only on cycles where slow_tick_i is high. Any number of main-clock cycles without a tick leaves the wait pending.
- R7: warm_rst_o or cold_rst_o is held for ASSERT_CYCLES cycles (default 4). The two are never high together.
- R8: dom_rst_o rises directly after the warm or cold pulse and stays high for (stretch_sel_i + 1) × 88 cycles. stretch_sel_i is a 2-bit value.
- R9: A request that arrives while a sequence is running has no effect. After the running sequence ends, the block stays idle.
- R10: last_cold_o changes only when the stretch phase ends. It is then 1 after a cold sequence and 0 after a warm one.
- R11: bypass_sel_i and stretch_sel_i are sampled when the request is accepted. Later changes do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| warm_req_i | input | 1 | Warm reset request, sampled while idle |
| warm_en_i | input | 1 | 1 = serve requests as warm resets, 0 = always cold |
| bypass_sel_i | input | 2 | Acknowledge timeout select |
| stretch_sel_i | input | 2 | Domain reset stretch select |
| slow_tick_i | input | 1 | One-cycle enable per slow reference period |
| mem_ack_i | input | 1 | Memory controller safe-state acknowledge |
| mem_req_o | output | 1 | Request to memory controller to reach a safe state |
| warm_rst_o | output | 1 | Warm reset pulse |
| cold_rst_o | output | 1 | Cold reset pulse |
| dom_rst_o | output | 1 | Stretched peripheral domain reset |
| last_cold_o | output | 1 | 1 = last completed sequence was cold |

## Verification
A state register that is wrong shows up at the ports within one cycle. For example, a missed acknowledge leaves mem_req_o high, and a wrong branch raises the wrong reset pulse in the cycle after the deciding input.

Faults in the counters take longer to appear. An off-by-one in the tick counter only shows on the tick that reaches the limit, so the bench steps to one tick below each limit and then past it. An error in the stretch length only shows when dom_rst_o falls, so each width setting is measured in whole cycles. An error in the status register is caught by reading last_cold_o both during the stretch phase and after it.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_WARM,
    ST_COLD,
    ST_STRETCH
  } seq_state_e;
endpackage

// File: rtl/wrst_timeout.sv
module wrst_timeout #(
  parameter int BASE_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  localparam int MaxTicks = BASE_TICKS * 4;
  localparam int TW       = $clog2(MaxTicks + 1);

  logic [TW-1:0] cnt_q, limit;

  // sel 0 disables the timeout; otherwise the limit doubles per step
  always_comb begin
    if (sel_i == 2'd0) limit = '0;
    else               limit = TW'(BASE_TICKS) << (sel_i - 2'd1);
  end

  assign expired_o = (limit != '0) && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + TW'(1);
  end

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wrst_cnt.sv
module wrst_cnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wrst_seq.sv
module wrst_seq
  import wrst_pkg::*;
#(
  parameter int ASSERT_CYCLES = 4,
  parameter int UNIT_CYCLES   = 88,
  parameter int BASE_TICKS    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       warm_req_i,
  input  logic       warm_en_i,
  input  logic [1:0] bypass_sel_i,
  input  logic [1:0] stretch_sel_i,
  input  logic       slow_tick_i,
  input  logic       mem_ack_i,
  output logic       mem_req_o,
  output logic       warm_rst_o,
  output logic       cold_rst_o,
  output logic       dom_rst_o,
  output logic       last_cold_o
);
  localparam int MaxLen = (ASSERT_CYCLES > 4 * UNIT_CYCLES) ? ASSERT_CYCLES : 4 * UNIT_CYCLES;
  localparam int CW     = $clog2(MaxLen + 1);

  seq_state_e    state_q, state_d;
  logic [1:0]    byp_q, str_q;
  logic          cold_q, last_cold_q;
  logic          cnt_load, cnt_zero, expired;
  logic [CW-1:0] cnt_val, assert_len, stretch_len;

  assign assert_len  = CW'(ASSERT_CYCLES - 1);
  assign stretch_len = (CW'(str_q) + CW'(1)) * CW'(UNIT_CYCLES) - CW'(1);

  wrst_timeout #(.BASE_TICKS(BASE_TICKS)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_WAIT_ACK),
    .tick_i   (slow_tick_i),
    .sel_i    (byp_q),
    .expired_o(expired)
  );

  wrst_cnt #(.W(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .zero_o    (cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = assert_len;
    unique case (state_q)
      ST_IDLE: if (warm_req_i) begin
        if (warm_en_i) state_d = ST_WAIT_ACK;
        else begin
          state_d  = ST_COLD;
          cnt_load = 1'b1;
        end
      end
      ST_WAIT_ACK: begin
        // acknowledge wins over a timeout in the same cycle
        if (mem_ack_i) begin
          state_d  = ST_WARM;
          cnt_load = 1'b1;
        end else if (expired) begin
          state_d  = ST_COLD;
          cnt_load = 1'b1;
        end
      end
      ST_WARM, ST_COLD: if (cnt_zero) begin
        state_d  = ST_STRETCH;
        cnt_load = 1'b1;
        cnt_val  = stretch_len;
      end
      ST_STRETCH: if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      byp_q       <= '0;
      str_q       <= '0;
      cold_q      <= 1'b0;
      last_cold_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && warm_req_i) begin
        byp_q <= bypass_sel_i;
        str_q <= stretch_sel_i;
      end
      if (state_d == ST_COLD && state_q != ST_COLD) cold_q <= 1'b1;
      if (state_d == ST_WARM && state_q != ST_WARM) cold_q <= 1'b0;
      if (state_q == ST_STRETCH && cnt_zero) last_cold_q <= cold_q;
    end
  end

  assign mem_req_o   = (state_q == ST_WAIT_ACK);
  assign warm_rst_o  = (state_q == ST_WARM);
  assign cold_rst_o  = (state_q == ST_COLD);
  assign dom_rst_o   = (state_q == ST_STRETCH);
  assign last_cold_o = last_cold_q;

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(warm_rst_o && cold_rst_o));
  a_r2_disabled_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && !warm_rst_o && !cold_rst_o && !dom_rst_o && warm_req_i && !warm_en_i)
    |=> (cold_rst_o && !mem_req_o));
  a_r3_ack_warm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> warm_rst_o);
  a_r4_timeout_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && expired) |=> cold_rst_o);
  a_r8_dom_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dom_rst_o) |-> $past(warm_rst_o || cold_rst_o));
  a_r10_status_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dom_rst_o |=> $stable(last_cold_o));
endmodule

// File: tb/wrst_seq_bench.sv
module wrst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ASSERT_N   = 4;
  localparam int UNIT       = 88;

  logic clk = 1'b0, rst_n = 1'b0;
  logic warm_req = 0, warm_en = 0, slow_tick = 0, mem_ack = 0;
  logic [1:0] bypass_sel = 0, stretch_sel = 0;
  logic mem_req, warm_rst, cold_rst, dom_rst, last_cold;

  int checks = 0, errors = 0;
  int n_req = 0, n_warm = 0, n_cold = 0, n_dom = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrst_seq u_wrst_seq (
    .clk_i(clk), .rst_ni(rst_n), .warm_req_i(warm_req), .warm_en_i(warm_en),
    .bypass_sel_i(bypass_sel), .stretch_sel_i(stretch_sel), .slow_tick_i(slow_tick),
    .mem_ack_i(mem_ack), .mem_req_o(mem_req), .warm_rst_o(warm_rst),
    .cold_rst_o(cold_rst), .dom_rst_o(dom_rst), .last_cold_o(last_cold)
  );

  always @(negedge clk) if (rst_n) begin
    n_req  <= n_req  + int'(mem_req);
    n_warm <= n_warm + int'(warm_rst);
    n_cold <= n_cold + int'(cold_rst);
    n_dom  <= n_dom  + int'(dom_rst);
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) warm_req = 1;
    @(negedge clk) warm_req = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) mem_ack = 1;
    @(negedge clk) mem_ack = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_tick = 1;
      @(negedge clk) slow_tick = 0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !dom_rst; i++) @(negedge clk);
    for (int i = 0; i < 3000 && dom_rst; i++) @(negedge clk);
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", mem_req, 0);
    chk("R1 warm", warm_rst, 0);
    chk("R1 cold", cold_rst, 0);
    chk("R1 dom", dom_rst, 0);
    chk("R1 last_cold", last_cold, 0);
  endtask

  task automatic t_disabled();
    int r0 = n_req, c0 = n_cold, w0 = n_warm, d0 = n_dom;
    warm_en = 0; stretch_sel = 0;
    @(negedge clk) warm_req = 1;
    @(negedge clk) warm_req = 0;
    chk("R2 cold next cycle", cold_rst, 1);
    wait_done();
    chk("R2 no mem_req", n_req - r0, 0);
    chk("R7 cold width", n_cold - c0, ASSERT_N);
    chk("R7 no warm", n_warm - w0, 0);
    chk("R8 stretch sel0", n_dom - d0, UNIT);
    chk("R10 last cold", last_cold, 1);
  endtask

  task automatic t_warm_ack(logic [1:0] ssel);
    int w0 = n_warm, c0 = n_cold, d0 = n_dom;
    warm_en = 1; bypass_sel = 0; stretch_sel = ssel;
    pulse_req();
    stretch_sel = ~ssel; // R11: must not alter this sequence
    chk("R3 mem_req raised", mem_req, 1);
    ticks(100);
    chk("R4 sel0 still waiting", mem_req, 1);
    chk("R4 sel0 no reset", (n_warm - w0) + (n_cold - c0), 0);
    @(negedge clk) mem_ack = 1;
    @(negedge clk) mem_ack = 0;
    chk("R3 warm after ack", warm_rst, 1);
    chk("R3 mem_req dropped", mem_req, 0);
    for (int i = 0; i < 20 && !dom_rst; i++) @(negedge clk);
    chk("R10 held during stretch", last_cold, 1);
    wait_done();
    chk("R7 warm width", n_warm - w0, ASSERT_N);
    chk("R7 no cold", n_cold - c0, 0);
    chk($sformatf("R8 R11 stretch sel%0d", ssel), n_dom - d0, (int'(ssel) + 1) * UNIT);
    chk("R10 last warm", last_cold, 0);
    @(negedge clk) warm_en = 0;
    pulse_req(); // return status to cold for the next run
    wait_done();
  endtask

  task automatic t_timeout(logic [1:0] bsel, int limit);
    int w0 = n_warm, c0 = n_cold;
    warm_en = 1; bypass_sel = bsel; stretch_sel = 0;
    pulse_req();
    bypass_sel = 2'd0; // R11: captured value keeps the timeout
    ticks(limit - 1);
    idle(200);
    chk($sformatf("R6 sel%0d pending after %0d ticks", bsel, limit - 1), mem_req, 1);
    chk("R6 no reset yet", (n_warm - w0) + (n_cold - c0), 0);
    ticks(1);
    @(negedge clk);
    chk($sformatf("R4 sel%0d cold on timeout", bsel), cold_rst, 1);
    wait_done();
    chk("R4 no warm", n_warm - w0, 0);
    chk("R10 cold status", last_cold, 1);
  endtask

  task automatic t_ack_before_limit();
    int w0 = n_warm, c0 = n_cold;
    warm_en = 1; bypass_sel = 1; stretch_sel = 0;
    pulse_req();
    ticks(15);
    pulse_ack();
    wait_done();
    chk("R5 warm before limit", n_warm - w0, ASSERT_N);
    chk("R5 no cold", n_cold - c0, 0);
  endtask

  task automatic t_busy_ignore();
    int r0, w0, c0;
    warm_en = 0; stretch_sel = 0;
    pulse_req();
    for (int i = 0; i < 20 && !dom_rst; i++) @(negedge clk);
    @(negedge clk) warm_en = 1;
    pulse_req();
    r0 = n_req; w0 = n_warm; c0 = n_cold;
    wait_done();
    idle(20);
    chk("R9 no mem_req after busy request", n_req - r0, 0);
    chk("R9 no further reset", (n_warm - w0) + (n_cold - c0), 0);
    chk("R9 idle", int'(mem_req | dom_rst), 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    idle(2);
    t_reset();
    t_disabled();
    t_warm_ack(2'd1);
    t_warm_ack(2'd3);
    t_timeout(2'd1, 16);
    t_timeout(2'd2, 32);
    t_timeout(2'd3, 64);
    t_ack_before_limit();
    t_busy_ignore();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule